// File: doc/BRIEF.md
# Late-Frame Transaction Start Gate

This block decides, at the moment a scheduler wants to launch another bus transaction, whether enough of the current bus frame is left for that transaction to finish. It counts bit times from a frame-start pulse. Once the count reaches a late sample point, it refuses every further start until the next frame begins. A host scheduler uses it to fill the spare time at the end of a frame with extra control or bulk work, and never lets a transaction run past the frame boundary.

The sample point is `FRAME_BITS - guard`. There are two guards. One is sized for a worst-case 32-byte packet and the other for a worst-case 64-byte packet. Each guard covers token, data, CRC, handshake and bus turnaround time. The 64-byte guard is the larger one, so its sample point is the earlier of the two. Software picks the guard with a select bit. The block latches that bit only on frame start. The block also gives a one-cycle pulse when the count reaches the last bit time of the frame.

Top module: `eof_txn_gate`

## Requirements
- R1: After reset, no output is asserted. Until the first `frame_start`, every start request is denied.
- R2: `frame_start` sets the bit position to 0, even when `bit_tick` is high in the same cycle. Otherwise each cycle with `bit_tick` high adds one to the position. The position stops at `FRAME_BITS-1` and stays there until the next `frame_start`.
- R3: `frame_end` is high for exactly one cycle. That cycle is the one after the clock edge at which a `bit_tick` moves the position from `FRAME_BITS-2` to `FRAME_BITS-1`.
- R4: The cycle after a cycle with `start_req` high, exactly one of `start_grant` and `start_deny` is high.
- R5: A request is granted when the bit position in its cycle is below the active sample point, which is `FRAME_BITS - guard`.
- R6: A request made when the position equals the sample point is denied. A request made at any later position is also denied, until the next `frame_start`.
- R7: `big_pkt_sel = 1` picks the 64-byte guard `GUARD_64`, which gives the earlier sample point. `big_pkt_sel = 0` picks the 32-byte guard `GUARD_32`.
- R8: `big_pkt_sel` is sampled only in a cycle with `frame_start` high. A change in the middle of a frame takes effect at the next frame.
- R9: A request in the same cycle as `frame_start` is judged at position 0 against the select value present in that cycle.
- R10: In a cycle without a request, `start_grant` and `start_deny` both stay low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that starts a new frame |
| bit_tick | input | 1 | One bit time has elapsed |
| big_pkt_sel | input | 1 | 1: 64-byte guard, 0: 32-byte guard (latched at frame start) |
| start_req | input | 1 | Request to launch a transaction |
| start_grant | output | 1 | Request of the previous cycle may start |
| start_deny | output | 1 | Request of the previous cycle must not start |
| frame_end | output | 1 | Pulse when the last bit time of the frame is reached |

## Verification
Each result is registered once. A grant or deny answers the request of the previous cycle. The frame-end pulse shows up one cycle after the tick that reaches the last bit time. The bench changes its inputs on the falling edge and keeps a reference model of position and select that advances once per cycle. It predicts all three outputs for the next cycle from the inputs it has just applied. It then waits one rising edge and compares on the following falling edge, so every comparison falls in the one cycle in which the result is due.

// File: rtl/eof_gate_pkg.sv
// Package: shared types and helper function for the late-frame start gate.
// Assumes: a guard is always smaller than the frame length.
package eof_gate_pkg;

    typedef enum logic {
        PKT_32 = 1'b0,
        PKT_64 = 1'b1
    } pkt_size_e;

    // Returns the bit position at which new starts stop being allowed.
    function automatic int unsigned cut_point(input int unsigned frame_bits,
                                              input int unsigned guard);
        return frame_bits - guard;
    endfunction

endpackage

// File: rtl/eof_bit_timer.sv
// Module: counts bit times inside a frame and flags arrival at the last one.
// Assumes: frame_start and bit_tick are synchronous single-cycle strobes;
// the count stops at the last bit time until the next frame starts.
module eof_bit_timer #(
    parameter int unsigned FRAME_BITS = 12000,
    localparam int unsigned POS_W     = $clog2(FRAME_BITS),
    localparam int unsigned LAST_POS  = FRAME_BITS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             bit_tick,
    output logic [POS_W-1:0] pos,
    output logic             frame_end
);

    localparam logic [POS_W-1:0] LAST_V = POS_W'(LAST_POS);
    localparam logic [POS_W-1:0] PRE_V  = POS_W'(LAST_POS - 1);

    // Purpose: reload on frame start, count ticks, stop at the last bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= LAST_V;
        end else if (frame_start) begin
            pos <= '0;
        end else if (bit_tick && pos != LAST_V) begin
            pos <= pos + 1'b1;
        end
    end

    // Purpose: one-cycle pulse when the count steps onto the last bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_end <= 1'b0;
        end else begin
            frame_end <= !frame_start && bit_tick && (pos == PRE_V);
        end
    end

    // R2
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_V);

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> pos == '0);

    // R3
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R3
    end_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> pos == LAST_V);

endmodule

// File: rtl/eof_sample_point.sv
// Module: holds the packet-size selection for the frame and provides the
// sample point that applies in the current cycle.
// Assumes: in a frame-start cycle, the incoming select is already in force.
module eof_sample_point
    import eof_gate_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 12000,
    parameter int unsigned GUARD_32   = 420,
    parameter int unsigned GUARD_64   = 760,
    localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             big_pkt_sel,
    output logic [POS_W-1:0] sample_pt
);

    localparam int unsigned N_SIZES = 2;
    localparam int unsigned GUARDS [N_SIZES] = '{GUARD_32, GUARD_64};

    logic [POS_W-1:0] pt_table [N_SIZES];
    pkt_size_e        size_q;
    pkt_size_e        size_now;

    // Purpose: one cut point per packet size, built from the guard list.
    for (genvar g = 0; g < N_SIZES; g++) begin : g_pt
        assign pt_table[g] = POS_W'(cut_point(FRAME_BITS, GUARDS[g]));
    end

    // Purpose: latch the size selection only when a frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= PKT_32;
        end else if (frame_start) begin
            size_q <= pkt_size_e'(big_pkt_sel);
        end
    end

    // Purpose: a frame-start cycle already uses the new selection.
    always_comb begin
        size_now  = frame_start ? pkt_size_e'(big_pkt_sel) : size_q;
        sample_pt = pt_table[size_now];
    end

    initial begin
        if (GUARD_64 <= GUARD_32 || GUARD_64 >= FRAME_BITS)
            $error("guards must satisfy GUARD_32 < GUARD_64 < FRAME_BITS");
    end

    // R8
    size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(size_q));

endmodule

// File: rtl/eof_start_judge.sv
// Module: answers each start request one cycle later with grant or deny.
// Assumes: pos and sample_pt already reflect a frame start in the same cycle.
module eof_start_judge #(
    parameter int unsigned FRAME_BITS = 12000,
    localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             start_req,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] sample_pt,
    output logic             start_grant,
    output logic             start_deny
);

    logic [POS_W-1:0] pos_now;
    logic             room_left;

    // Purpose: position as seen by a request, treating frame start as zero.
    always_comb begin
        pos_now   = frame_start ? '0 : pos;
        room_left = pos_now < sample_pt;
    end

    // Purpose: register the decision for the request of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_grant <= 1'b0;
            start_deny  <= 1'b0;
        end else begin
            start_grant <= start_req && room_left;
            start_deny  <= start_req && !room_left;
        end
    end

    // R4
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> (start_grant ^ start_deny));

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_req |=> !start_grant && !start_deny);

endmodule

// File: rtl/eof_txn_gate.sv
// Module: top of the late-frame start gate. Tracks bit time within a frame
// and refuses transaction starts at or after the selected sample point.
// Assumes: one frame_start per frame; bit_tick at the bus bit rate.
module eof_txn_gate #(
    parameter int unsigned FRAME_BITS = 12000,
    parameter int unsigned GUARD_32   = 420,
    parameter int unsigned GUARD_64   = 760
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic bit_tick,
    input  logic big_pkt_sel,
    input  logic start_req,
    output logic start_grant,
    output logic start_deny,
    output logic frame_end
);

    localparam int unsigned POS_W = $clog2(FRAME_BITS);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] sample_pt;

    eof_bit_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .bit_tick    (bit_tick),
        .pos         (pos),
        .frame_end   (frame_end)
    );

    eof_sample_point #(
        .FRAME_BITS (FRAME_BITS),
        .GUARD_32   (GUARD_32),
        .GUARD_64   (GUARD_64)
    ) u_point (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .big_pkt_sel (big_pkt_sel),
        .sample_pt   (sample_pt)
    );

    eof_start_judge #(.FRAME_BITS(FRAME_BITS)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .start_req   (start_req),
        .pos         (pos),
        .sample_pt   (sample_pt),
        .start_grant (start_grant),
        .start_deny  (start_deny)
    );

    // R6
    late_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !frame_start && pos >= sample_pt) |=> start_deny);

    // R9
    fresh_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && frame_start) |=> start_grant);

endmodule

// File: tb/eof_txn_gate_tb.sv
module eof_txn_gate_tb;

    localparam int unsigned FB   = 300;
    localparam int unsigned G32  = 40;
    localparam int unsigned G64  = 70;
    localparam int unsigned LAST = FB - 1;
    localparam int unsigned WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic bit_tick = 1'b0;
    logic big_pkt_sel = 1'b0;
    logic start_req = 1'b0;
    logic start_grant, start_deny, frame_end;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    int unsigned m_pos = LAST;
    bit          m_sel = 1'b0;

    always #2 clk = ~clk;

    eof_txn_gate #(.FRAME_BITS(FB), .GUARD_32(G32), .GUARD_64(G64)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_tick(bit_tick),
        .big_pkt_sel(big_pkt_sel), .start_req(start_req),
        .start_grant(start_grant), .start_deny(start_deny), .frame_end(frame_end)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic int unsigned point_for(input bit sel);
        return sel ? FB - G64 : FB - G32;
    endfunction

    // One cycle: apply inputs, predict, advance model, compare after the edge.
    task automatic step(input bit fs, input bit tk, input bit sel, input bit rq,
                        input string tag);
        int unsigned eff_pos;
        bit          eff_sel, e_g, e_d, e_e;
        frame_start = fs; bit_tick = tk; big_pkt_sel = sel; start_req = rq;
        eff_pos = fs ? 0 : m_pos;
        eff_sel = fs ? sel : m_sel;
        e_g = rq && (eff_pos < point_for(eff_sel));
        e_d = rq && !(eff_pos < point_for(eff_sel));
        e_e = !fs && tk && (m_pos == LAST - 1);
        if (fs) begin
            m_pos = 0; m_sel = sel;
        end else if (tk && m_pos < LAST) begin
            m_pos = m_pos + 1;
        end
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (start_grant !== e_g || start_deny !== e_d || frame_end !== e_e) begin
            n_bad++;
            $display("FAIL %s: actual g=%b d=%b e=%b expected g=%b d=%b e=%b",
                     tag, start_grant, start_deny, frame_end, e_g, e_d, e_e);
        end
    endtask

    task automatic go_to(input int unsigned target, input bit sel);
        while (m_pos != target) step(1'b0, 1'b1, sel, 1'b0, "R2");
    endtask

    initial begin
        int unsigned seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, deny before any frame
        n_cmp++;
        if (start_grant !== 1'b0 || start_deny !== 1'b0 || frame_end !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: actual %b%b%b expected 000", start_grant, start_deny, frame_end);
        end
        step(1'b0, 1'b0, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R1");
        // R9: request in the frame-start cycle
        step(1'b1, 1'b1, 1'b0, 1'b1, "R9");
        // R10: no request, no answer
        step(1'b0, 1'b1, 1'b0, 1'b0, "R10");
        // R5 and R6 with the 32-byte point (260)
        go_to(FB - G32 - 1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R6");
        // R8: select change mid-frame has no effect this frame
        go_to(LAST - 1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1, "R3");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R6");
        // R7: 64-byte point (230)
        step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
        go_to(FB - G64 - 1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R8");
        go_to(FB - G32 - 2, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1, "R8");
        // R4: random traffic
        for (int i = 0; i < 4000; i++) begin
            bit fs, tk, sl, rq;
            fs = (m_pos == LAST) ? ($urandom % 3 == 0) : ($urandom % 400 == 0);
            tk = ($urandom % 4) != 0;
            sl = ($urandom % 2) == 1;
            rq = ($urandom % 5) == 0;
            step(fs, tk, sl, rq, "R4");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule